// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Flow-Through

This block is a first-in first-out buffer for 9-bit words. Its depth is 2**ADDR_W words. The default is 2048, and any power of two from 2048 to 65536 is supported. Writers and readers drive active-low strobes instead of clock enables. A write is committed when the write strobe rises. The oldest word is presented on the output while the read strobe is low, and it is consumed when the read strobe rises. An output-enable bit marks the interval in which the data bus would be driven, so a three-state bus can be modelled.

Both strobes are sampled by the block clock through a two-stage synchronizer, and their edges are found in that clock domain. The block reports three active-low status flags: empty, full and more-than-half-full. Two flow-through sequences are supported:

- **Read flow-through.** A reader waits with its strobe low on an empty buffer. It receives the next written word as soon as that word lands.
- **Write flow-through.** A writer waits with its strobe low on a full buffer. It reclaims the slot freed by a read.

A rewind input sends the read side back to the first location so that data can be replayed. Several instances that share strobes, reset and rewind form a wider word, and the flags of any one instance describe the whole group.

Top module: `strobe_fifo`

## Requirements
- R1: A word is stored when the write strobe `wr_n` goes from low to high, provided the count is below the depth. The stored value is the `din` held while the strobe was low. Words leave in the order they were written.
- R2: `empty_n` is low exactly when no word is stored. `full_n` is low when the count equals the depth, and also during the reservation described in R7.
- R3: `half_n` is low exactly when the stored count is greater than half the depth.
- R4: A write-strobe rise while the count equals the depth stores nothing. A read-strobe rise while empty removes nothing.
- R5: `dout_oe` is high only while the synchronized read strobe is low and the buffer holds a word. `dout` then shows the oldest word, which is removed when `rd_n` rises.
- R6: Read flow-through. If `rd_n` is held low on an empty buffer and a word is written, then `empty_n` goes high and `dout_oe` goes high with that word on `dout`. After `rd_n` rises, `dout_oe` drops and `empty_n` returns low.
- R7: Write flow-through. A read rise on a full buffer raises `full_n` for one clock. If `wr_n` is already low at that point, `full_n` goes low again and stays low. The next `wr_n` rise stores the word, and the buffer is full again.
- R8: Synchronous active-high `rst` empties the buffer: `empty_n`=0, `full_n`=1, `half_n`=1. Strobe activity while `rst` is high has no effect.
- R9: A clock with `rewind` high sets the read location to the first location and leaves the write location unchanged. The count becomes the write location index, and later reads replay from the first word.
- R10: A write rise and a read rise committed in the same clock, with the buffer neither empty nor full, leave the count unchanged. The oldest word is removed and the new word is appended.
- R11: Two instances sharing strobes, reset and rewind show identical flags and `dout_oe` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write strobe, committed on its rising edge |
| rd_n | input | 1 | Active-low read strobe, consumed on its rising edge |
| rewind | input | 1 | Returns the read side to the first location |
| din | input | 9 | Write data, held stable while `wr_n` is low |
| dout | output | 9 | Oldest stored word |
| dout_oe | output | 1 | High while `dout` would drive the bus |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full or while a freed slot is reserved |
| half_n | output | 1 | Low when more than half full |

## Verification
The assertions assume that each strobe level lasts at least three sampling clocks, so every edge survives the synchronizer as one rise pulse. They also assume `din` is steady for the whole low phase of `wr_n`, and that rewind is used only after fewer writes than the depth since reset. The bench keeps every strobe level for four clocks. It changes `din` only together with the falling write strobe, and it rewinds only after a partial fill that follows a reset. The pointers wrap through sweeps over an 8-word configuration.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    localparam int WORD_W = 9;

    typedef logic [WORD_W-1:0] word_t;

    // Strobe activity as seen in the sampling clock domain
    typedef struct packed {
        logic wr_rise;
        logic rd_rise;
        logic wr_low;
        logic rd_low;
    } strobe_evt_t;

    // Active-low status outputs
    typedef struct packed {
        logic empty_n;
        logic full_n;
        logic half_n;
    } flags_t;

    function automatic logic rise_of(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] held_low,
    output logic [N-1:0] released
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                meta_q <= strobe_n[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign held_low[i] = ~sync_q;
        assign released[i] = strobe_fifo_pkg::rise_of(sync_q, prev_q);
    end
endmodule

// File: rtl/strobe_fifo_store.sv
module strobe_fifo_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rewind,
    input  logic              wr_rise,
    input  logic              rd_rise,
    input  logic              wr_low,
    output logic              do_wr,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output flags_t            flags
);
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [CNT_W-1:0] CNT_NEAR = {1'b0, {ADDR_W{1'b1}}};
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_FULL >> 1;

    logic [CNT_W-1:0] count_q, count_d;
    logic             from_full_q, hold_q, hold_d;
    logic             do_rd, is_full, is_empty;

    assign is_full  = (count_q == CNT_FULL);
    assign is_empty = (count_q == '0);
    assign do_wr    = wr_rise & ~is_full & ~rewind;
    assign do_rd    = rd_rise & ~is_empty & ~rewind;

    always_comb begin
        count_d = count_q;
        if (do_wr & ~do_rd) count_d = count_q + {{ADDR_W{1'b0}}, 1'b1};
        if (do_rd & ~do_wr) count_d = count_q - {{ADDR_W{1'b0}}, 1'b1};
    end

    // Slot reservation for a writer waiting on a full buffer
    always_comb begin
        hold_d = hold_q;
        if (do_wr || do_rd || !wr_low)
            hold_d = 1'b0;
        else if (from_full_q && count_q == CNT_NEAR)
            hold_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr      <= '0;
            rd_ptr      <= '0;
            count_q     <= '0;
            from_full_q <= 1'b0;
            hold_q      <= 1'b0;
        end else if (rewind) begin
            rd_ptr      <= '0;
            count_q     <= {1'b0, wr_ptr};
            from_full_q <= 1'b0;
            hold_q      <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            count_q     <= count_d;
            from_full_q <= do_rd & ~do_wr & is_full;
            hold_q      <= hold_d;
        end
    end

    assign flags.empty_n = ~is_empty;
    assign flags.full_n  = ~(is_full | hold_q);
    assign flags.half_n  = ~(count_q > CNT_HALF);

    a_r4_full_blocks_write: assert property (@(posedge clk) disable iff (rst)
        (is_full && wr_rise && !rewind) |=> $stable(wr_ptr));

    a_r4_empty_blocks_read: assert property (@(posedge clk) disable iff (rst)
        (is_empty && rd_rise && !rewind) |=> $stable(rd_ptr));

    a_r10_pair_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (wr_rise && rd_rise && !is_empty && !is_full && !rewind) |=> $stable(count_q));

    a_r9_rewind_home: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (rd_ptr == '0));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_FULL);

    a_r7_hold_near_full: assert property (@(posedge clk) disable iff (rst)
        hold_q |-> (count_q == CNT_NEAR));
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              rewind,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_oe,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);
    strobe_evt_t       evt;
    flags_t            flags;
    logic [1:0]        low_v, rise_v;
    word_t             din_m_q, din_s_q, wdata_q;
    logic              do_wr;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;

    strobe_sync #(.N(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n ({rd_n, wr_n}),
        .held_low (low_v),
        .released (rise_v)
    );

    assign evt.wr_low  = low_v[0];
    assign evt.rd_low  = low_v[1];
    assign evt.wr_rise = rise_v[0];
    assign evt.rd_rise = rise_v[1];

    // Data follows the same two stages as the strobe; the word kept is the
    // last one seen while the write strobe was low.
    always_ff @(posedge clk) begin
        if (rst) begin
            din_m_q <= '0;
            din_s_q <= '0;
            wdata_q <= '0;
        end else begin
            din_m_q <= din;
            din_s_q <= din_m_q;
            if (evt.wr_low) wdata_q <= din_s_q;
        end
    end

    strobe_fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .rewind  (rewind),
        .wr_rise (evt.wr_rise),
        .rd_rise (evt.rd_rise),
        .wr_low  (evt.wr_low),
        .do_wr   (do_wr),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .flags   (flags)
    );

    strobe_fifo_store #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (do_wr),
        .waddr (wr_ptr),
        .wdata (wdata_q),
        .raddr (rd_ptr),
        .rdata (dout)
    );

    assign dout_oe = evt.rd_low & flags.empty_n;
    assign empty_n = flags.empty_n;
    assign full_n  = flags.full_n;
    assign half_n  = flags.half_n;

    a_r8_reset_empties: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!empty_n && full_n && half_n && !dout_oe));
endmodule

// File: tb/strobe_fifo_test.sv
module strobe_fifo_test;
    localparam int AW = 3;
    localparam int BD = 1 << AW;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_n = 1'b1, rd_n = 1'b1, rewind = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout, dout_b;
    logic       dout_oe, empty_n, full_n, half_n;
    logic       oe_b, empty_b, full_b, half_b;

    int vectors = 0, fails = 0, xp_err = 0;
    int mdl [BD];
    int mhead = 0, mtail = 0, mcnt = 0;

    always #5 clk = ~clk;

    strobe_fifo #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rewind(rewind),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n));

    strobe_fifo #(.ADDR_W(AW)) uut_b (
        .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rewind(rewind),
        .din(~din), .dout(dout_b), .dout_oe(oe_b),
        .empty_n(empty_b), .full_n(full_b), .half_n(half_b));

    // R11: width expansion monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (empty_b != empty_n || full_b != full_n || half_b != half_n || oe_b != dout_oe)
                xp_err++;
            if (dout_oe && dout_b != ~dout) xp_err++;
        end
    end

    task automatic check_val(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_flags(input string req);
        check_val(req, "empty_n", int'(empty_n), int'(mcnt != 0));
        check_val(req, "full_n", int'(full_n), int'(mcnt != BD));
        check_val("R3", "half_n", int'(half_n), int'(!(mcnt > BD / 2)));
    endtask

    task automatic push(input int d);
        if (mcnt < BD) begin
            mdl[mtail] = d;
            mtail = (mtail + 1) % BD;
            mcnt++;
        end
    endtask

    task automatic pop();
        if (mcnt > 0) begin
            mhead = (mhead + 1) % BD;
            mcnt--;
        end
    endtask

    task automatic write_word(input int d);
        @(negedge clk);
        din = 9'(d);
        wr_n = 1'b0;
        idle(4);
        wr_n = 1'b1;
        idle(4);
        push(d);
    endtask

    task automatic read_word(input string req);
        @(negedge clk);
        rd_n = 1'b0;
        idle(4);
        if (mcnt > 0) begin
            check_val(req, "dout_oe", int'(dout_oe), 1);
            check_val("R1", "dout", int'(dout), mdl[mhead]);
        end else begin
            check_val("R4", "dout_oe on empty", int'(dout_oe), 0);
        end
        rd_n = 1'b1;
        idle(4);
        pop();
    endtask

    task automatic clear_model();
        mhead = 0; mtail = 0; mcnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(2);
        clear_model();
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        bit saw;
        idle(4);
        rst = 1'b0;
        idle(2);
        // R8 reset state
        check_flags("R8");
        check_val("R8", "dout_oe", int'(dout_oe), 0);

        // R1 R2 R3 R4 sweeps with wrap-around
        for (int r = 0; r < 3; r++) begin
            int n = (r == 0) ? BD + 1 : 5 + r;
            for (int i = 0; i < n; i++) begin
                write_word((r * 37 + i * 11 + 3) % 512);
                check_flags("R2");
            end
            for (int i = 0; i <= n; i++) begin
                read_word("R5");
                check_flags("R2");
            end
        end

        // R6 read flow-through
        @(negedge clk);
        rd_n = 1'b0;
        idle(4);
        check_val("R6", "dout_oe empty", int'(dout_oe), 0);
        check_val("R6", "empty_n", int'(empty_n), 0);
        din = 9'h1A5;
        wr_n = 1'b0;
        idle(4);
        wr_n = 1'b1;
        saw = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (empty_n) saw = 1'b1;
        end
        check_val("R6", "empty_n pulse", int'(saw), 1);
        check_val("R6", "dout_oe", int'(dout_oe), 1);
        check_val("R6", "dout", int'(dout), 'h1A5);
        rd_n = 1'b1;
        idle(5);
        check_val("R6", "dout_oe after rise", int'(dout_oe), 0);
        check_val("R6", "empty_n after rise", int'(empty_n), 0);

        // R7 write flow-through
        for (int i = 0; i < BD; i++) write_word(200 + i);
        check_flags("R7");
        @(negedge clk);
        rd_n = 1'b0;
        idle(4);
        check_val("R7", "dout", int'(dout), mdl[mhead]);
        din = 9'h0F0;
        wr_n = 1'b0;
        idle(4);
        rd_n = 1'b1;
        saw = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (full_n) saw = 1'b1;
        end
        pop();
        check_val("R7", "full_n pulse", int'(saw), 1);
        check_val("R7", "full_n reasserted", int'(full_n), 0);
        wr_n = 1'b1;
        idle(5);
        push('h0F0);
        check_flags("R7");
        for (int i = 0; i < BD; i++) read_word("R7");
        check_flags("R7");

        // R10 simultaneous edges
        for (int i = 0; i < 5; i++) write_word(300 + i);
        @(negedge clk);
        rd_n = 1'b0;
        wr_n = 1'b0;
        din = 9'd77;
        idle(4);
        check_val("R10", "dout", int'(dout), mdl[mhead]);
        rd_n = 1'b1;
        wr_n = 1'b1;
        idle(5);
        pop();
        push(77);
        check_flags("R10");
        for (int i = 0; i < 5; i++) read_word("R10");
        check_flags("R10");

        // R9 rewind
        do_reset();
        for (int i = 0; i < 5; i++) write_word(100 + i);
        read_word("R9");
        read_word("R9");
        @(negedge clk);
        rewind = 1'b1;
        @(negedge clk);
        rewind = 1'b0;
        idle(2);
        mhead = 0;
        mcnt = 5;
        check_flags("R9");
        for (int i = 0; i < 5; i++) read_word("R9");
        check_flags("R9");

        // R8 strobes ignored under reset, reset empties
        for (int i = 0; i < 3; i++) write_word(400 + i);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            wr_n = 1'b0; idle(4);
            wr_n = 1'b1; idle(4);
        end
        rst = 1'b0;
        idle(6);
        clear_model();
        check_flags("R8");
        @(negedge clk);
        rd_n = 1'b0;
        idle(4);
        check_val("R8", "dout_oe after reset", int'(dout_oe), 0);
        rd_n = 1'b1;
        idle(4);

        check_val("R11", "expansion mismatches", xp_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule